// File: doc/BRIEF.md
# Block-Transfer Mailbox Register Block

This block is the management-controller side of a byte-wide block-transfer mailbox that a host reaches over a simple register bus. The host sees three registers. The first is a handshake register that carries busy and attention flags. The second is a single data port that moves message bytes. The third is an interrupt-mask register whose top bit asks the controller to reset its side of the mailbox.

Behind the data port are two 64-byte buffers. One holds requests the host writes in. The other holds responses the controller has loaded for the host to read. A host write of zero to the handshake register never changes it. A written one sets, clears or toggles its bit, depending on the bit, so the host never needs a read-modify-write.

On its own side, the controller loads response bytes by address. It reads request bytes by address and sees how many request bytes the host has written. It has one strobe for each flag it owns, and it receives a one-cycle reset request pulse.

Top module: `bt_mbox_regs`

## Requirements
- R1: After reset every flag, both pointers and the mask register are 0. The handshake register at offset 0xE4 reads {bBusy[7], hBusy[6], oem0[5], smsAtn[4], b2hAtn[3], h2bAtn[2], 0, 0}. The data port is at 0xE5 and the mask register is at 0xE6.
- R2: Writing 0 to any handshake bit leaves that bit unchanged.
- R3: Writing 1 to bit 6 (hBusy) or to bit 5 (oem0) of the handshake register toggles that bit.
- R4: Writing 1 to bit 2 sets h2bAtn. Only the controller strobe `bmcClrH2bAtn` clears it. If the host set and the controller clear fall in the same cycle, the set wins.
- R5: The controller strobes set b2hAtn and smsAtn. The host clears either one by writing 1 to bit 3 or bit 4. If a controller set and a host clear fall in the same cycle, the set wins. Only the controller strobes change bBusy, and host writes to bit 7 have no effect.
- R6: A host write to the data port stores the byte at the request write pointer and then advances the pointer. `bmcH2bLevel` shows the pointer, and `bmcH2bRdata` returns the byte at `bmcH2bAddr`.
- R7: A host read of the data port returns the response byte at the read pointer and advances the pointer. Bytes therefore come out in the order they were loaded.
- R8: Writing 1 to bit 1 of the handshake register zeroes the read pointer. Writing 1 to bit 0 zeroes the write pointer. Both bits always read back as 0.
- R9: A host write to 0xE6 with bit 7 set clears both pointers and all three attention flags at that clock edge. It also drives `bmcResetReq` high for exactly the following cycle. Mask bit 7 reads back as 0, and mask bits 6:0 hold the written value.
- R10: Both pointers wrap modulo 64.
- R11: Accesses to any other offset read as 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostSel | input | 1 | Host access valid this cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 8 | Host register offset |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational) |
| bmcB2hWe | input | 1 | Controller writes a response byte |
| bmcB2hAddr | input | 6 | Response buffer address |
| bmcB2hWdata | input | 8 | Response byte |
| bmcH2bAddr | input | 6 | Request buffer read address |
| bmcH2bRdata | output | 8 | Request byte at that address |
| bmcH2bLevel | output | 6 | Request write pointer |
| bmcSetB2hAtn | input | 1 | Set response attention |
| bmcSetSmsAtn | input | 1 | Set event attention |
| bmcClrH2bAtn | input | 1 | Clear request attention |
| bmcSetBBusy | input | 1 | Set controller busy |
| bmcClrBBusy | input | 1 | Clear controller busy |
| bBusy | output | 1 | Controller busy flag |
| hBusy | output | 1 | Host busy flag |
| oem0 | output | 1 | Spare flag |
| smsAtn | output | 1 | Event attention flag |
| b2hAtn | output | 1 | Response attention flag |
| h2bAtn | output | 1 | Request attention flag |
| bmcResetReq | output | 1 | One-cycle reset request pulse |

## Verification
Host reads are combinational, so the bench samples read data in the same cycle as the access, before the clock edge that advances the pointer. Every flag, pointer and buffer effect of a write or strobe appears one edge later, so the bench samples it just after that edge. The reset request pulse is checked high right after the mask write's edge and low after the next edge. The same-cycle races between controller and host are driven together in one cycle so that the priority rule decides the outcome.

// File: rtl/bt_mbox_pkg.sv
package bt_mbox_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] CTRL_OFS = 8'hE4;
  localparam logic [7:0] DATA_OFS = 8'hE5;
  localparam logic [7:0] MASK_OFS = 8'hE6;
  localparam int BIT_BBUSY = 7;
  localparam int BIT_HBUSY = 6;
  localparam int BIT_OEM0 = 5;
  localparam int BIT_SMS = 4;
  localparam int BIT_B2H = 3;
  localparam int BIT_H2B = 2;
  localparam int BIT_ZRD = 1;
  localparam int BIT_ZWR = 0;
  localparam int BIT_RST = 7;

  typedef struct packed {
    logic pushH2b;
    logic popB2h;
    logic zeroRd;
    logic zeroWr;
  } bt_strobe_t;
endpackage

// File: rtl/bt_mbox_ctrl.sv
module bt_mbox_ctrl
  import bt_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [7:0]        hostAddr,
  input  logic [BYTE_W-1:0] hostWdata,
  output logic [BYTE_W-1:0] hostRdata,
  input  logic [BYTE_W-1:0] b2hByte,
  input  logic              bmcSetB2hAtn,
  input  logic              bmcSetSmsAtn,
  input  logic              bmcClrH2bAtn,
  input  logic              bmcSetBBusy,
  input  logic              bmcClrBBusy,
  output logic              bBusy,
  output logic              hBusy,
  output logic              oem0,
  output logic              smsAtn,
  output logic              b2hAtn,
  output logic              h2bAtn,
  output logic              bmcResetReq,
  output bt_strobe_t        strobe
);
  logic ctrlWr, dataWr, dataRd, maskWr, rstHit;
  logic [6:0] maskReg;

  assign ctrlWr = hostSel && hostWr && (hostAddr == CTRL_OFS);
  assign dataWr = hostSel && hostWr && (hostAddr == DATA_OFS);
  assign dataRd = hostSel && !hostWr && (hostAddr == DATA_OFS);
  assign maskWr = hostSel && hostWr && (hostAddr == MASK_OFS);
  assign rstHit = maskWr && hostWdata[BIT_RST];

  always_comb begin
    strobe.pushH2b = dataWr;
    strobe.popB2h  = dataRd;
    strobe.zeroRd  = rstHit || (ctrlWr && hostWdata[BIT_ZRD]);
    strobe.zeroWr  = rstHit || (ctrlWr && hostWdata[BIT_ZWR]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bBusy       <= 1'b0;
      hBusy       <= 1'b0;
      oem0        <= 1'b0;
      smsAtn      <= 1'b0;
      b2hAtn      <= 1'b0;
      h2bAtn      <= 1'b0;
      maskReg     <= '0;
      bmcResetReq <= 1'b0;
    end else begin
      bmcResetReq <= rstHit;
      if (ctrlWr && hostWdata[BIT_HBUSY]) hBusy <= !hBusy;
      if (ctrlWr && hostWdata[BIT_OEM0])  oem0  <= !oem0;
      if (bmcSetBBusy)      bBusy <= 1'b1;
      else if (bmcClrBBusy) bBusy <= 1'b0;
      if (maskWr) maskReg <= hostWdata[6:0];

      if (rstHit)                              smsAtn <= 1'b0;
      else if (bmcSetSmsAtn)                   smsAtn <= 1'b1;
      else if (ctrlWr && hostWdata[BIT_SMS])   smsAtn <= 1'b0;

      if (rstHit)                              b2hAtn <= 1'b0;
      else if (bmcSetB2hAtn)                   b2hAtn <= 1'b1;
      else if (ctrlWr && hostWdata[BIT_B2H])   b2hAtn <= 1'b0;

      if (rstHit)                              h2bAtn <= 1'b0;
      else if (ctrlWr && hostWdata[BIT_H2B])   h2bAtn <= 1'b1;
      else if (bmcClrH2bAtn)                   h2bAtn <= 1'b0;
    end
  end

  always_comb begin
    hostRdata = '0;
    if (hostSel && !hostWr) begin
      unique case (hostAddr)
        CTRL_OFS: hostRdata = {bBusy, hBusy, oem0, smsAtn, b2hAtn, h2bAtn, 2'b00};
        DATA_OFS: hostRdata = b2hByte;
        MASK_OFS: hostRdata = {1'b0, maskReg};
        default:  hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bt_mbox_data.sv
module bt_mbox_data
  import bt_mbox_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bt_strobe_t        strobe,
  input  logic [BYTE_W-1:0] hostWdata,
  output logic [BYTE_W-1:0] b2hByte,
  input  logic              bmcB2hWe,
  input  logic [PTR_W-1:0]  bmcB2hAddr,
  input  logic [BYTE_W-1:0] bmcB2hWdata,
  input  logic [PTR_W-1:0]  bmcH2bAddr,
  output logic [BYTE_W-1:0] bmcH2bRdata,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr
);
  logic [BYTE_W-1:0] h2bMem [DEPTH];
  logic [BYTE_W-1:0] b2hMem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.zeroWr)       wrPtr <= '0;
      else if (strobe.pushH2b) wrPtr <= wrPtr + 1'b1;
      if (strobe.zeroRd)       rdPtr <= '0;
      else if (strobe.popB2h)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.pushH2b) h2bMem[wrPtr] <= hostWdata;
    if (bmcB2hWe)       b2hMem[bmcB2hAddr] <= bmcB2hWdata;
  end

  assign b2hByte     = b2hMem[rdPtr];
  assign bmcH2bRdata = h2bMem[bmcH2bAddr];
endmodule

// File: rtl/bt_mbox_regs.sv
module bt_mbox_regs
  import bt_mbox_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [7:0]        hostAddr,
  input  logic [BYTE_W-1:0] hostWdata,
  output logic [BYTE_W-1:0] hostRdata,
  input  logic              bmcB2hWe,
  input  logic [PTR_W-1:0]  bmcB2hAddr,
  input  logic [BYTE_W-1:0] bmcB2hWdata,
  input  logic [PTR_W-1:0]  bmcH2bAddr,
  output logic [BYTE_W-1:0] bmcH2bRdata,
  output logic [PTR_W-1:0]  bmcH2bLevel,
  input  logic              bmcSetB2hAtn,
  input  logic              bmcSetSmsAtn,
  input  logic              bmcClrH2bAtn,
  input  logic              bmcSetBBusy,
  input  logic              bmcClrBBusy,
  output logic              bBusy,
  output logic              hBusy,
  output logic              oem0,
  output logic              smsAtn,
  output logic              b2hAtn,
  output logic              h2bAtn,
  output logic              bmcResetReq
);
  bt_strobe_t        strobe;
  logic [BYTE_W-1:0] b2hByte;
  logic [PTR_W-1:0]  rdPtr;

  bt_mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .b2hByte(b2hByte), .bmcSetB2hAtn(bmcSetB2hAtn), .bmcSetSmsAtn(bmcSetSmsAtn),
    .bmcClrH2bAtn(bmcClrH2bAtn), .bmcSetBBusy(bmcSetBBusy), .bmcClrBBusy(bmcClrBBusy),
    .bBusy(bBusy), .hBusy(hBusy), .oem0(oem0), .smsAtn(smsAtn), .b2hAtn(b2hAtn),
    .h2bAtn(h2bAtn), .bmcResetReq(bmcResetReq), .strobe(strobe)
  );

  bt_mbox_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWdata(hostWdata),
    .b2hByte(b2hByte), .bmcB2hWe(bmcB2hWe), .bmcB2hAddr(bmcB2hAddr),
    .bmcB2hWdata(bmcB2hWdata), .bmcH2bAddr(bmcH2bAddr), .bmcH2bRdata(bmcH2bRdata),
    .wrPtr(bmcH2bLevel), .rdPtr(rdPtr)
  );
endmodule

// File: rtl/bt_mbox_chk.sv
module bt_mbox_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostSel,
  input logic             hostWr,
  input logic [7:0]       hostAddr,
  input logic [7:0]       hostWdata,
  input logic             bmcSetB2hAtn,
  input logic             bmcSetSmsAtn,
  input logic             bmcClrH2bAtn,
  input logic             bmcSetBBusy,
  input logic             bmcClrBBusy,
  input logic             bBusy,
  input logic             hBusy,
  input logic             oem0,
  input logic             smsAtn,
  input logic             b2hAtn,
  input logic             h2bAtn,
  input logic             bmcResetReq,
  input logic [PTR_W-1:0] bmcH2bLevel,
  input logic [PTR_W-1:0] rdPtr
);
  logic ctrlW, dataW, anyBmc;
  assign ctrlW  = hostSel && hostWr && hostAddr == 8'hE4;
  assign dataW  = hostSel && hostWr && hostAddr == 8'hE5;
  assign anyBmc = bmcSetB2hAtn || bmcSetSmsAtn || bmcClrH2bAtn || bmcSetBBusy || bmcClrBBusy;

  AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlW && hostWdata == 8'h00 && !anyBmc |=>
      $stable({bBusy, hBusy, oem0, smsAtn, b2hAtn, h2bAtn})); // R2
  AST_HBUSY_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    ctrlW && hostWdata[6] |=> hBusy != $past(hBusy)); // R3
  AST_H2B_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlW && hostWdata[2] |=> h2bAtn); // R4
  AST_BBUSY_HOST_BLIND: assert property (@(posedge clk) disable iff (!rstN)
    !bmcSetBBusy && !bmcClrBBusy |=> $stable(bBusy)); // R5
  AST_WRPTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    dataW |=> bmcH2bLevel == $past(bmcH2bLevel) + 1'b1); // R6
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    bmcResetReq |=> !bmcResetReq); // R9
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    bmcResetReq |-> !smsAtn && !b2hAtn && !h2bAtn && bmcH2bLevel == '0 && rdPtr == '0); // R9
endmodule

bind bt_mbox_regs bt_mbox_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
  .hostWdata(hostWdata), .bmcSetB2hAtn(bmcSetB2hAtn), .bmcSetSmsAtn(bmcSetSmsAtn),
  .bmcClrH2bAtn(bmcClrH2bAtn), .bmcSetBBusy(bmcSetBBusy), .bmcClrBBusy(bmcClrBBusy),
  .bBusy(bBusy), .hBusy(hBusy), .oem0(oem0), .smsAtn(smsAtn), .b2hAtn(b2hAtn),
  .h2bAtn(h2bAtn), .bmcResetReq(bmcResetReq), .bmcH2bLevel(bmcH2bLevel), .rdPtr(rdPtr)
);

// File: tb/test_bt_mbox_regs.sv
module test_bt_mbox_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0;
  logic [7:0] hostAddr = '0, hostWdata = '0;
  logic [7:0] hostRdata;
  logic bmcB2hWe = 1'b0;
  logic [5:0] bmcB2hAddr = '0, bmcH2bAddr = '0;
  logic [7:0] bmcB2hWdata = '0, bmcH2bRdata;
  logic [5:0] bmcH2bLevel;
  logic bmcSetB2hAtn = 0, bmcSetSmsAtn = 0, bmcClrH2bAtn = 0, bmcSetBBusy = 0, bmcClrBBusy = 0;
  logic bBusy, hBusy, oem0, smsAtn, b2hAtn, h2bAtn, bmcResetReq;
  int checks = 0, failures = 0;

  always #10 clk = !clk;

  bt_mbox_regs i_bt_mbox_regs (.*);

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] dat;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'hE4, 8'h00, 8'd1},  // R1 reset value
    '{1'b1, 8'hE4, 8'h00, 8'd2},  // R2 write zeros
    '{1'b0, 8'hE4, 8'h00, 8'd2},
    '{1'b1, 8'hE4, 8'h40, 8'd3},  // R3 toggle hBusy
    '{1'b0, 8'hE4, 8'h40, 8'd3},
    '{1'b1, 8'hE4, 8'h20, 8'd3},  // R3 toggle oem0
    '{1'b0, 8'hE4, 8'h60, 8'd3},
    '{1'b1, 8'hE4, 8'h04, 8'd4},  // R4 host sets h2bAtn
    '{1'b0, 8'hE4, 8'h64, 8'd4},
    '{1'b1, 8'hE4, 8'h40, 8'd3},  // R3 toggle hBusy back
    '{1'b0, 8'hE4, 8'h24, 8'd3},
    '{1'b1, 8'hE4, 8'h80, 8'd5},  // R5 host cannot touch bBusy
    '{1'b0, 8'hE4, 8'h24, 8'd5},
    '{1'b0, 8'hE5, 8'hA0, 8'd7},  // R7 in-order response bytes
    '{1'b0, 8'hE5, 8'hA1, 8'd7},
    '{1'b1, 8'hE4, 8'h02, 8'd8},  // R8 zero read pointer
    '{1'b0, 8'hE4, 8'h24, 8'd8},
    '{1'b0, 8'hE5, 8'hA0, 8'd8},
    '{1'b0, 8'hE7, 8'h00, 8'd11}, // R11 unmapped reads 0
    '{1'b1, 8'hE6, 8'h05, 8'd9},  // R9 mask low bits stored
    '{1'b0, 8'hE6, 8'h05, 8'd9}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk); #1;
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #2 d = hostRdata;
    @(posedge clk); #1;
    hostSel = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    check("R1 reset level", {2'b00, bmcH2bLevel}, 8'h00);
    check("R1 reset resetReq", {7'd0, bmcResetReq}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bmcB2hWe = 1'b1; bmcB2hAddr = 6'(i); bmcB2hWdata = 8'hA0 + 8'(i);
      @(posedge clk); #1 bmcB2hWe = 1'b0;
    end

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v].wr) hostWrite(VEC[v].addr, VEC[v].dat);
      else begin
        hostRead(VEC[v].addr, rd);
        check($sformatf("R%0d vector %0d", VEC[v].req, v), rd, VEC[v].dat);
      end
    end

    // R6 request bytes land in order and the level follows
    hostWrite(8'hE5, 8'h11);
    hostWrite(8'hE5, 8'h22);
    check("R6 level", {2'b00, bmcH2bLevel}, 8'h02);
    bmcH2bAddr = 6'd1; #1;
    check("R6 byte1", bmcH2bRdata, 8'h22);

    // R8 / R10 zero write pointer then wrap after 65 bytes
    hostWrite(8'hE4, 8'h01);
    check("R8 wr ptr zeroed", {2'b00, bmcH2bLevel}, 8'h00);
    for (int i = 0; i < 65; i++) hostWrite(8'hE5, 8'(i));
    check("R10 level after wrap", {2'b00, bmcH2bLevel}, 8'h01);
    bmcH2bAddr = 6'd0; #1;
    check("R10 overwritten byte", bmcH2bRdata, 8'd64);

    // R4 controller clears h2bAtn
    @(negedge clk); bmcClrH2bAtn = 1'b1; @(posedge clk); #1 bmcClrH2bAtn = 1'b0;
    check("R4 cleared by controller", {7'd0, h2bAtn}, 8'h00);
    // R4 same-cycle host set beats controller clear
    @(negedge clk);
    hostSel = 1; hostWr = 1; hostAddr = 8'hE4; hostWdata = 8'h04; bmcClrH2bAtn = 1'b1;
    @(posedge clk); #1 hostSel = 0; hostWr = 0; bmcClrH2bAtn = 1'b0;
    check("R4 set wins", {7'd0, h2bAtn}, 8'h01);

    // R5 response attention set by controller, cleared by host
    @(negedge clk); bmcSetB2hAtn = 1'b1; @(posedge clk); #1 bmcSetB2hAtn = 1'b0;
    check("R5 b2h set", {7'd0, b2hAtn}, 8'h01);
    hostWrite(8'hE4, 8'h08);
    check("R5 b2h host clear", {7'd0, b2hAtn}, 8'h00);
    // R5 same-cycle event set beats host clear
    @(negedge clk);
    hostSel = 1; hostWr = 1; hostAddr = 8'hE4; hostWdata = 8'h10; bmcSetSmsAtn = 1'b1;
    @(posedge clk); #1 hostSel = 0; hostWr = 0; bmcSetSmsAtn = 1'b0;
    check("R5 sms set wins", {7'd0, smsAtn}, 8'h01);
    hostWrite(8'hE4, 8'h10);
    check("R5 sms host clear", {7'd0, smsAtn}, 8'h00);
    @(negedge clk); bmcSetBBusy = 1'b1; @(posedge clk); #1 bmcSetBBusy = 1'b0;
    hostRead(8'hE4, rd);
    check("R5 bBusy via controller", rd, 8'hA4);

    // R11 write to unmapped offset changes nothing
    hostWrite(8'hE7, 8'hFF);
    hostRead(8'hE4, rd);
    check("R11 ctrl unchanged", rd, 8'hA4);
    hostRead(8'hE6, rd);
    check("R11 mask unchanged", rd, 8'h05);

    // R9 reset request pulse and its clearing effect
    @(negedge clk); bmcSetB2hAtn = 1'b1; @(posedge clk); #1 bmcSetB2hAtn = 1'b0;
    hostRead(8'hE5, rd);
    hostWrite(8'hE6, 8'h85);
    check("R9 pulse high", {7'd0, bmcResetReq}, 8'h01);
    check("R9 atn cleared", {5'd0, smsAtn, b2hAtn, h2bAtn}, 8'h00);
    check("R9 level cleared", {2'b00, bmcH2bLevel}, 8'h00);
    @(posedge clk); #1;
    check("R9 pulse low", {7'd0, bmcResetReq}, 8'h00);
    hostRead(8'hE6, rd);
    check("R9 mask bit7 reads 0", rd, 8'h05);
    hostRead(8'hE5, rd);
    check("R9 rd ptr cleared", rd, 8'hA0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule